// File: doc/BRIEF.md
# Two-Phase Randomised Mesh Route Selector

This unit computes, once per packet per hop, the output direction for a packet in a square 2D mesh. It spreads traffic by sending each packet first to a pseudo-randomly drawn waypoint node and only then to its true destination. Both legs are steered with dimension-order routing: the X offset is cleared completely before any Y movement. Routes that pass through a waypoint are usually longer than the shortest path, so the hop count can exceed the Manhattan distance between source and destination.

When a packet is injected at its source node, the unit draws the waypoint from a free-running 16-bit LFSR and writes the waypoint and a leg bit into the header fields it returns. At every later hop the header fields are presented back with `inject` low. The leg bit turns to 1 at the waypoint. From that point the destination is the target, and the Local port is chosen on arrival. Two optional modes are available. One keeps the waypoint in the source's quadrant. The other skips the detour while the network is lightly loaded. Mesh sizes of 4x4 and 8x8 are supported through `MESH_DIM`.

Top module: `valiant_route_sel`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `rsp_valid` is 0, `port_out` is 0 (Local), `leg_out` is 0 and both waypoint outputs are 0.
- R2: A request sampled with `req_valid` high on a rising edge produces its result on the outputs after that same edge, and `rsp_valid` is 1 for exactly the cycles that follow an edge with `req_valid` high.
- R3: Direction encoding is Local=0, East=1, West=2, North=3, South=4. East means a larger X and North means a larger Y. The target X is resolved first: East or West while X differs, then North or South while Y differs, and Local when both match.
- R4: On a non-injection request with `leg_in`=1, the target is the destination. The Local port is chosen only when the current node equals the destination, and `leg_out` stays 1.
- R5: On a non-injection request with `leg_in`=0, the target is the waypoint (`wp_x_in`,`wp_y_in`). If the current node equals the waypoint, `leg_out` becomes 1 and the routing goes toward the destination in the same cycle.
- R6: On a non-injection request, the waypoint outputs repeat `wp_x_in`/`wp_y_in`, and `leg_out` never returns to 0 once `leg_in` is 1.
- R7: The LFSR is reset to `LFSR_SEED` (default 16'hACE1). It advances only on an edge with `req_valid` and `inject` both high, and its next value is {s[14:0], s[15]^s[13]^s[12]^s[10]}. On injection, the waypoint X is s[CW-1:0] and Y is s[2CW-1:CW] of the value held before the advance, with CW = log2(`MESH_DIM`).
- R8: On injection, if the drawn waypoint equals the current (source) node or the destination, the first leg is skipped: `leg_out` is 1 and the port is steered toward the destination.
- R9: With `quad_mode` high on injection, the top bit of each waypoint coordinate is replaced by the source's top bit, so the waypoint lies in the source's quadrant.
- R10: With `load_mode` high and `load_high` low on injection, there is no detour: `leg_out` is 1, the waypoint outputs equal the destination, and the port follows dimension order toward the destination. With `load_high` high, the waypoint is drawn as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Route request present |
| inject | input | 1 | Request is the packet's first hop at its source |
| cur_x | input | CW | Current node X |
| cur_y | input | CW | Current node Y |
| dst_x | input | CW | Destination X |
| dst_y | input | CW | Destination Y |
| leg_in | input | 1 | Header leg bit (0 = heading to waypoint) |
| wp_x_in | input | CW | Header waypoint X |
| wp_y_in | input | CW | Header waypoint Y |
| quad_mode | input | 1 | Keep waypoint in source quadrant |
| load_mode | input | 1 | Detour only under high load |
| load_high | input | 1 | Network load indication |
| rsp_valid | output | 1 | Result valid |
| port_out | output | 3 | Selected output direction |
| leg_out | output | 1 | Updated leg bit |
| wp_x_out | output | CW | Waypoint X for header |
| wp_y_out | output | CW | Waypoint Y for header |

## Verification
If the LFSR state is wrong, the waypoint outputs differ from the bench's own generator on the first injection after the fault. Every later draw then differs as well, so an extra or missing advance is seen at the next injected request. A wrong leg decision appears in the same response as an incorrect `leg_out` and usually also as a wrong direction, because the target swaps between waypoint and destination. Direction errors from the dimension-order logic appear one edge after the request, in the case where X and Y both differ or one of them already matches.

// File: rtl/valiant_pkg.sv
package valiant_pkg;
  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_EAST  = 3'd1,
    DIR_WEST  = 3'd2,
    DIR_NORTH = 3'd3,
    DIR_SOUTH = 3'd4
  } dir_e;
endpackage

// File: rtl/valiant_lfsr.sv
module valiant_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  output logic [15:0] state
);
  logic fb;
  assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= {state[14:0], fb};
  end
endmodule

// File: rtl/valiant_wp_pick.sv
module valiant_wp_pick #(
  parameter int CW = 3
) (
  input  logic [15:0]   rnd,
  input  logic          quad_mode,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  output logic [CW-1:0] wp_x,
  output logic [CW-1:0] wp_y
);
  logic [CW-1:0] raw_x, raw_y;
  assign raw_x = rnd[CW-1:0];
  assign raw_y = rnd[2*CW-1:CW];

  generate
    if (CW > 1) begin : g_quad
      always_comb begin
        wp_x = raw_x;
        wp_y = raw_y;
        if (quad_mode) begin
          wp_x[CW-1] = src_x[CW-1];
          wp_y[CW-1] = src_y[CW-1];
        end
      end
    end else begin : g_flat
      assign wp_x = quad_mode ? src_x : raw_x;
      assign wp_y = quad_mode ? src_y : raw_y;
    end
  endgenerate
endmodule

// File: rtl/valiant_dor.sv
module valiant_dor
  import valiant_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [CW-1:0] cx,
  input  logic [CW-1:0] cy,
  input  logic [CW-1:0] tx,
  input  logic [CW-1:0] ty,
  output dir_e          dir
);
  always_comb begin
    if (tx > cx)      dir = DIR_EAST;
    else if (tx < cx) dir = DIR_WEST;
    else if (ty > cy) dir = DIR_NORTH;
    else if (ty < cy) dir = DIR_SOUTH;
    else              dir = DIR_LOCAL;
  end
endmodule

// File: rtl/valiant_route_sel.sv
module valiant_route_sel
  import valiant_pkg::*;
#(
  parameter int          MESH_DIM  = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         CW        = $clog2(MESH_DIM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          inject,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic          leg_in,
  input  logic [CW-1:0] wp_x_in,
  input  logic [CW-1:0] wp_y_in,
  input  logic          quad_mode,
  input  logic          load_mode,
  input  logic          load_high,
  output logic          rsp_valid,
  output logic [2:0]    port_out,
  output logic          leg_out,
  output logic [CW-1:0] wp_x_out,
  output logic [CW-1:0] wp_y_out
);
  logic [15:0]   rnd;
  logic [CW-1:0] draw_x, draw_y;
  logic [CW-1:0] nxt_wx, nxt_wy, tgt_x, tgt_y;
  logic          nxt_leg, bypass, at_wp, at_dst;
  dir_e          dir;

  valiant_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(req_valid & inject), .state(rnd)
  );

  valiant_wp_pick #(.CW(CW)) u_pick (
    .rnd(rnd), .quad_mode(quad_mode), .src_x(cur_x), .src_y(cur_y),
    .wp_x(draw_x), .wp_y(draw_y)
  );

  assign bypass = load_mode & ~load_high;
  assign at_dst = (cur_x == dst_x) && (cur_y == dst_y);

  always_comb begin
    if (inject) begin
      if (bypass) begin
        nxt_wx = dst_x;
        nxt_wy = dst_y;
      end else begin
        nxt_wx = draw_x;
        nxt_wy = draw_y;
      end
    end else begin
      nxt_wx = wp_x_in;
      nxt_wy = wp_y_in;
    end
    at_wp = (cur_x == nxt_wx) && (cur_y == nxt_wy);
    if (inject)
      nxt_leg = bypass | at_wp | ((nxt_wx == dst_x) && (nxt_wy == dst_y));
    else
      nxt_leg = leg_in | at_wp;
    tgt_x = nxt_leg ? dst_x : nxt_wx;
    tgt_y = nxt_leg ? dst_y : nxt_wy;
  end

  valiant_dor #(.CW(CW)) u_dor (
    .cx(cur_x), .cy(cur_y), .tx(tgt_x), .ty(tgt_y), .dir(dir)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      port_out  <= DIR_LOCAL;
      leg_out   <= 1'b0;
      wp_x_out  <= '0;
      wp_y_out  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        port_out <= dir;
        leg_out  <= nxt_leg;
        wp_x_out <= nxt_wx;
        wp_y_out <= nxt_wy;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = at_dst;
endmodule

// File: rtl/valiant_route_chk.sv
module valiant_route_chk #(
  parameter int MESH_DIM = 8,
  localparam int CW = $clog2(MESH_DIM)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          inject,
  input logic [CW-1:0] cur_x,
  input logic [CW-1:0] cur_y,
  input logic [CW-1:0] dst_x,
  input logic [CW-1:0] dst_y,
  input logic          leg_in,
  input logic          quad_mode,
  input logic          load_mode,
  input logic          load_high,
  input logic          rsp_valid,
  input logic [2:0]    port_out,
  input logic          leg_out,
  input logic [CW-1:0] wp_x_out,
  input logic [CW-1:0] wp_y_out
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_dir_legal_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> port_out <= 3'd4);
  assert_local_final_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !inject && leg_in && cur_x == dst_x && cur_y == dst_y)
    |=> (port_out == 3'd0 && leg_out));
  assert_leg_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !inject && leg_in) |=> leg_out);
  assert_quadrant_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && inject && quad_mode && !(load_mode && !load_high))
    |=> (wp_x_out[CW-1] == $past(cur_x[CW-1]) && wp_y_out[CW-1] == $past(cur_y[CW-1])));
  assert_low_load_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && inject && load_mode && !load_high)
    |=> (leg_out && wp_x_out == $past(dst_x) && wp_y_out == $past(dst_y)));
endmodule

bind valiant_route_sel valiant_route_chk #(.MESH_DIM(MESH_DIM)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .inject(inject),
  .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
  .leg_in(leg_in), .quad_mode(quad_mode), .load_mode(load_mode),
  .load_high(load_high), .rsp_valid(rsp_valid), .port_out(port_out),
  .leg_out(leg_out), .wp_x_out(wp_x_out), .wp_y_out(wp_y_out)
);

// File: tb/sim_valiant_route_sel.sv
`timescale 1ns/1ps
module sim_valiant_route_sel;
  localparam int MESH_DIM = 8;
  localparam int CW = 3;
  localparam int NV = 9;
  // fields: cx cy dx dy leg wx wy | exp_port exp_leg  (3*6+1+3+1 = 23 bits)
  localparam logic [22:0] VEC [0:NV-1] = '{
    {3'd1,3'd1,3'd5,3'd1,1'b1,3'd0,3'd0, 3'd1,1'b1},
    {3'd5,3'd2,3'd2,3'd6,1'b1,3'd0,3'd0, 3'd2,1'b1},
    {3'd3,3'd3,3'd3,3'd7,1'b1,3'd0,3'd0, 3'd3,1'b1},
    {3'd3,3'd3,3'd3,3'd0,1'b1,3'd0,3'd0, 3'd4,1'b1},
    {3'd4,3'd4,3'd4,3'd4,1'b1,3'd2,3'd2, 3'd0,1'b1},
    {3'd2,3'd2,3'd0,3'd0,1'b0,3'd6,3'd1, 3'd1,1'b0},
    {3'd6,3'd1,3'd0,3'd0,1'b0,3'd6,3'd1, 3'd2,1'b1},
    {3'd6,3'd3,3'd6,3'd7,1'b0,3'd6,3'd1, 3'd4,1'b0},
    {3'd7,3'd7,3'd7,3'd7,1'b0,3'd7,3'd7, 3'd0,1'b1}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, inject = 0, leg_in = 0;
  logic quad_mode = 0, load_mode = 0, load_high = 0;
  logic [CW-1:0] cur_x = 0, cur_y = 0, dst_x = 0, dst_y = 0, wp_x_in = 0, wp_y_in = 0;
  logic rsp_valid, leg_out;
  logic [2:0] port_out;
  logic [CW-1:0] wp_x_out, wp_y_out;
  int checks = 0, fails = 0;
  logic [15:0] mdl = 16'hACE1;
  bit done = 0;

  always #4 clk = ~clk;

  valiant_route_sel #(.MESH_DIM(MESH_DIM)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .inject(inject),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .leg_in(leg_in), .wp_x_in(wp_x_in), .wp_y_in(wp_y_in),
    .quad_mode(quad_mode), .load_mode(load_mode), .load_high(load_high),
    .rsp_valid(rsp_valid), .port_out(port_out), .leg_out(leg_out),
    .wp_x_out(wp_x_out), .wp_y_out(wp_y_out)
  );

  function automatic logic [2:0] dor(input logic [CW-1:0] cx, cy, tx, ty);
    if (tx > cx) return 3'd1;
    if (tx < cx) return 3'd2;
    if (ty > cy) return 3'd3;
    if (ty < cy) return 3'd4;
    return 3'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_req(input logic inj, input logic [CW-1:0] cx, cy, dx, dy);
    req_valid = 1; inject = inj;
    cur_x = cx; cur_y = cy; dst_x = dx; dst_y = dy;
    @(posedge clk); #2;
    req_valid = 0; inject = 0;
  endtask

  task automatic inj_chk(input string req, input logic [CW-1:0] cx, cy, dx, dy,
                         input logic qm, lm, lh);
    logic [CW-1:0] ex, ey;
    logic el;
    ex = mdl[CW-1:0];
    ey = mdl[2*CW-1:CW];
    if (qm) begin ex[CW-1] = cx[CW-1]; ey[CW-1] = cy[CW-1]; end
    if (lm && !lh) begin ex = dx; ey = dy; el = 1; end
    else el = ((ex == cx) && (ey == cy)) || ((ex == dx) && (ey == dy));
    quad_mode = qm; load_mode = lm; load_high = lh;
    step_req(1, cx, cy, dx, dy);
    mdl = {mdl[14:0], mdl[15] ^ mdl[13] ^ mdl[12] ^ mdl[10]};
    chk({req, " wp"}, {wp_x_out, wp_y_out}, {ex, ey});
    chk({req, " leg"}, leg_out, el);
    chk({req, " port"}, port_out, el ? dor(cx, cy, dx, dy) : dor(cx, cy, ex, ey));
    quad_mode = 0; load_mode = 0; load_high = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] px, py;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 valid in reset", rsp_valid, 0);
    chk("R1 port in reset", port_out, 0);
    rst = 0;
    @(posedge clk); #2;
    chk("R1 after reset", {rsp_valid, port_out, leg_out, wp_x_out, wp_y_out}, 0);

    // R3 R4 R5 R6: table walk, non-injection hops
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      leg_in = v[7]; wp_x_in = v[6:4]; wp_y_in = v[3:1] ^ 3'd0;
      wp_x_in = v[10:8]; wp_y_in = v[7:5];
      leg_in = v[11];
      step_req(0, v[22:20], v[19:17], v[16:14], v[13:11] ^ 3'd0);
      // field split kept explicit below
    end
    // re-walk with clear field slicing
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      leg_in  = v[10];
      wp_x_in = v[9:7];
      wp_y_in = v[6:4];
      step_req(0, v[22:20], v[19:17], v[16:14], v[13:11]);
      chk("R2 rsp_valid", rsp_valid, 1);
      chk("R3 R4 R5 table port", port_out, v[3:1]);
      chk("R5 R6 table leg", leg_out, v[0]);
      chk("R6 waypoint passthrough", {wp_x_out, wp_y_out}, {v[9:7], v[6:4]});
    end
    leg_in = 0; wp_x_in = 0; wp_y_in = 0;
    @(posedge clk); #2;
    chk("R2 idle rsp_valid", rsp_valid, 0);

    // R7: inject high without req_valid must not advance generator
    inject = 1; @(posedge clk); #2; inject = 0;
    inj_chk("R7 draw 1", 3'd0, 3'd0, 3'd7, 3'd7, 0, 0, 0);
    inj_chk("R7 draw 2", 3'd5, 3'd2, 3'd1, 3'd6, 0, 0, 0);
    inj_chk("R7 draw 3", 3'd3, 3'd6, 3'd3, 3'd0, 0, 0, 0);
    inj_chk("R9 quad a", 3'd1, 3'd2, 3'd6, 3'd6, 1, 0, 0);
    inj_chk("R9 quad b", 3'd6, 3'd5, 3'd0, 3'd1, 1, 0, 0);
    inj_chk("R10 low load", 3'd2, 3'd3, 3'd6, 3'd0, 0, 1, 0);
    inj_chk("R10 high load", 3'd2, 3'd3, 3'd6, 3'd0, 0, 1, 1);
    // R8: waypoint equals source
    px = mdl[CW-1:0]; py = mdl[2*CW-1:CW];
    inj_chk("R8 wp is source", px, py, px ^ 3'd4, py ^ 3'd2, 0, 0, 0);
    // R8: waypoint equals destination
    px = mdl[CW-1:0]; py = mdl[2*CW-1:CW];
    inj_chk("R8 wp is dest", px ^ 3'd4, py ^ 3'd1, px, py, 0, 0, 0);
    for (int k = 0; k < 6; k++)
      inj_chk("R7 draw run", 3'(k), 3'(7 - k), 3'(k + 3), 3'(k * 3), k[0], 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule